// File: doc/BRIEF.md
# Correlation Argmax Atom Selector

This block sits behind an inner-product datapath in a sparse-recovery engine. Each cycle the datapath may hand it one signed fixed-point correlation value, tagged with the dictionary column it belongs to. When the vectors are longer than the datapath, one column's correlation arrives as several partial sums. The block adds these partials together, turns each finished correlation into a magnitude, and keeps the largest magnitude seen so far in the sweep together with its column index.

When the final column of a sweep has been compared, the block pulses `done` with the winning index and magnitude. On the next clock it appends the index to a small active-set memory. A write pointer selects the slot. It advances on every append and returns to zero when a new reconstruction starts. A separate read port returns any stored index one cycle after the slot is presented, so later steps can use the chosen indices as fetch addresses for the selected columns.

Top module: `corr_argmax_sel`

## Requirements
- R1: After reset, `done` is 0, `slot_count` is 0, and a read of any slot returns 0.
- R2: One correlation value is the sum of `fold_sel`+1 consecutive accepted partials with the same column tag. The column tag is taken from the last of those partials. A `fold_sel` of 0 means no folding.
- R3: Each correlation's absolute value is compared with the held best. The larger one is kept with its column index, so `win_mag` equals the largest absolute correlation of the sweep and `win_idx` equals its column.
- R4: When two magnitudes are equal, the entry compared first is kept.
- R5: The most negative input, -2^(DATA_W-1), yields magnitude 2^(DATA_W-1) with no overflow or wrap.
- R6: `in_last` is meaningful only on the final partial of the final column. `done` is high for exactly the single cycle two clocks after that partial is accepted. `win_idx` and `win_mag` are valid in that cycle. Tracking then restarts empty for the next sweep.
- R7: In the cycle after `done`, the winning index is written to the slot addressed by `slot_count`, and `slot_count` increments modulo 2^SLOT_W.
- R8: A `start` pulse clears `slot_count` to 0. It also discards any partly summed column and any held best, but it leaves stored indices unchanged.
- R9: `rd_idx` shows the index stored in slot `rd_slot` one clock after `rd_slot` is presented.
- R10: Cycles with `in_valid` low have no effect, whatever `in_data`, `in_col` or `in_last` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start of a reconstruction: clears pointer and tracking |
| fold_sel | input | FOLD_W | Partials per column minus one |
| in_valid | input | 1 | Partial correlation present |
| in_last | input | 1 | Final partial of the final column |
| in_col | input | IDX_W | Column index of the partial |
| in_data | input | DATA_W | Signed partial correlation |
| done | output | 1 | One-cycle end-of-sweep pulse |
| win_idx | output | IDX_W | Winning column index |
| win_mag | output | DATA_W+FOLD_W+1 | Winning magnitude |
| slot_count | output | SLOT_W | Active-set write pointer |
| rd_slot | input | SLOT_W | Active-set read slot |
| rd_idx | output | IDX_W | Stored index, one cycle after rd_slot |

## Verification
The bench drives the most negative input, which a design without the extra magnitude bit would report as zero or as a negative magnitude and so would pick the wrong winner. It also drives an equal-magnitude pair of opposite signs, where a greater-or-equal compare would pick the later column. It injects idle cycles carrying random data and a raised last flag; a design that listens to them would end the sweep early or corrupt the sums. It pulses `start` in the middle of a folded column and while holding a large best value; if a stale phase or best survived, later correlations would be misaligned and a column from the previous reconstruction would win. Finally it runs more sweeps than there are slots, and a pointer that saturated or skipped would leave the wrong indices in the read-back memory.

// File: rtl/corr_sel_pkg.sv
package corr_sel_pkg;

    // Tracker occupancy: whether a best candidate is currently held.
    typedef enum logic {
        TRK_EMPTY = 1'b0,
        TRK_HOLD  = 1'b1
    } trk_state_e;

endpackage

// File: rtl/fold_accum.sv
module fold_accum #(
    parameter int DATA_W = 16,
    parameter int FOLD_W = 3,
    parameter int IDX_W  = 8,
    localparam int ACC_W = DATA_W + FOLD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic [FOLD_W-1:0]        fold_sel,
    input  logic                     in_valid,
    input  logic                     in_last,
    input  logic [IDX_W-1:0]         in_col,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     c_valid,
    output logic                     c_last,
    output logic [IDX_W-1:0]         c_col,
    output logic signed [ACC_W-1:0]  c_value
);

    typedef struct packed {
        logic [FOLD_W-1:0]       phase;
        logic signed [ACC_W-1:0] acc;
        logic                    cv;
        logic                    cl;
        logic [IDX_W-1:0]        ccol;
        logic signed [ACC_W-1:0] cval;
    } fold_st_t;

    fold_st_t st_d, st_q;
    logic signed [ACC_W-1:0] ext_d;
    logic signed [ACC_W-1:0] sum_d;

    always_comb begin
        st_d    = st_q;
        st_d.cv = 1'b0;
        st_d.cl = 1'b0;
        ext_d   = {{FOLD_W{in_data[DATA_W-1]}}, in_data};
        sum_d   = ((st_q.phase == '0) ? '0 : st_q.acc) + ext_d;
        if (clear) begin
            st_d.phase = '0;
            st_d.acc   = '0;
        end else if (in_valid) begin
            if (st_q.phase == fold_sel) begin
                st_d.cv    = 1'b1;
                st_d.cl    = in_last;
                st_d.ccol  = in_col;
                st_d.cval  = sum_d;
                st_d.phase = '0;
                st_d.acc   = '0;
            end else begin
                st_d.phase = st_q.phase + FOLD_W'(1);
                st_d.acc   = sum_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign c_valid = st_q.cv;
    assign c_last  = st_q.cl;
    assign c_col   = st_q.ccol;
    assign c_value = st_q.cval;

    // R10: a finished correlation only follows an accepted partial
    assert_corr_needs_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        c_valid |-> $past(in_valid));

endmodule

// File: rtl/mag_tracker.sv
module mag_tracker
    import corr_sel_pkg::*;
#(
    parameter int ACC_W = 19,
    parameter int IDX_W = 8,
    localparam int MAG_W = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    c_valid,
    input  logic                    c_last,
    input  logic [IDX_W-1:0]        c_col,
    input  logic signed [ACC_W-1:0] c_value,
    output logic                    done,
    output logic [IDX_W-1:0]        win_idx,
    output logic [MAG_W-1:0]        win_mag
);

    typedef struct packed {
        trk_state_e       have;
        logic [MAG_W-1:0] best_mag;
        logic [IDX_W-1:0] best_idx;
        logic             fin;
        logic [MAG_W-1:0] fin_mag;
        logic [IDX_W-1:0] fin_idx;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic signed [MAG_W-1:0] wide_d;
    logic [MAG_W-1:0]        mag_d;
    logic                    take_d;
    logic [MAG_W-1:0]        sel_mag_d;
    logic [IDX_W-1:0]        sel_idx_d;

    always_comb begin
        st_d      = st_q;
        st_d.fin  = 1'b0;
        wide_d    = {c_value[ACC_W-1], c_value};
        mag_d     = wide_d[MAG_W-1] ? MAG_W'(-wide_d) : MAG_W'(wide_d);
        // strictly greater: an equal later entry never displaces the held one
        take_d    = (st_q.have == TRK_EMPTY) || (mag_d > st_q.best_mag);
        sel_mag_d = take_d ? mag_d : st_q.best_mag;
        sel_idx_d = take_d ? c_col : st_q.best_idx;
        if (clear) begin
            st_d.have = TRK_EMPTY;
        end else if (c_valid) begin
            if (c_last) begin
                st_d.fin     = 1'b1;
                st_d.fin_mag = sel_mag_d;
                st_d.fin_idx = sel_idx_d;
                st_d.have    = TRK_EMPTY;
            end else begin
                st_d.have     = TRK_HOLD;
                st_d.best_mag = sel_mag_d;
                st_d.best_idx = sel_idx_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.fin;
    assign win_idx = st_q.fin_idx;
    assign win_mag = st_q.fin_mag;

    // R3: the held best never shrinks within a sweep
    assert_best_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_valid && !c_last && !clear && st_q.have == TRK_HOLD)
        |=> (st_q.best_mag >= $past(st_q.best_mag)));

    // R6: the reported winner is at least as large as the final compared entry
    assert_win_ge_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (win_mag >= $past(mag_d)));

endmodule

// File: rtl/active_set_mem.sv
module active_set_mem #(
    parameter int IDX_W  = 8,
    parameter int SLOT_W = 4,
    localparam int DEPTH = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [SLOT_W-1:0] wr_ptr,
    output logic [IDX_W-1:0]  rd_idx
);

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] mem;
        logic [SLOT_W-1:0]           ptr;
        logic [IDX_W-1:0]            rd;
    } aset_st_t;

    aset_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.rd = st_q.mem[rd_slot];
        if (clear) begin
            st_d.ptr = '0;
        end else if (wr_en) begin
            st_d.mem[st_q.ptr] = wr_idx;
            st_d.ptr           = st_q.ptr + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.ptr;
    assign rd_idx = st_q.rd;

    // R7: each append advances the pointer by one slot, wrapping
    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> (wr_ptr == $past(wr_ptr) + SLOT_W'(1)));

    // R8: a start returns the pointer to slot zero
    assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (wr_ptr == '0));

endmodule

// File: rtl/corr_argmax_sel.sv
module corr_argmax_sel #(
    parameter int DATA_W = 16,
    parameter int FOLD_W = 3,
    parameter int IDX_W  = 8,
    parameter int SLOT_W = 4,
    localparam int ACC_W = DATA_W + FOLD_W,
    localparam int MAG_W = ACC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FOLD_W-1:0] fold_sel,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [IDX_W-1:0]  in_col,
    input  logic [DATA_W-1:0] in_data,
    output logic              done,
    output logic [IDX_W-1:0]  win_idx,
    output logic [MAG_W-1:0]  win_mag,
    output logic [SLOT_W-1:0] slot_count,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [IDX_W-1:0]  rd_idx
);

    logic                    c_valid;
    logic                    c_last;
    logic [IDX_W-1:0]        c_col;
    logic signed [ACC_W-1:0] c_value;

    fold_accum #(
        .DATA_W(DATA_W), .FOLD_W(FOLD_W), .IDX_W(IDX_W)
    ) u_fold (
        .clk(clk), .rst_n(rst_n), .clear(start), .fold_sel(fold_sel),
        .in_valid(in_valid), .in_last(in_last), .in_col(in_col),
        .in_data($signed(in_data)),
        .c_valid(c_valid), .c_last(c_last), .c_col(c_col), .c_value(c_value)
    );

    mag_tracker #(
        .ACC_W(ACC_W), .IDX_W(IDX_W)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .c_valid(c_valid), .c_last(c_last), .c_col(c_col), .c_value(c_value),
        .done(done), .win_idx(win_idx), .win_mag(win_mag)
    );

    active_set_mem #(
        .IDX_W(IDX_W), .SLOT_W(SLOT_W)
    ) u_aset (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .wr_en(done), .wr_idx(win_idx), .rd_slot(rd_slot),
        .wr_ptr(slot_count), .rd_idx(rd_idx)
    );

    // R6: a sweep end is reported only after a finished final correlation
    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(c_valid) && $past(c_last)));

endmodule

// File: tb/sim_corr_argmax_sel.sv
module sim_corr_argmax_sel;

    localparam int DATA_W = 16;
    localparam int FOLD_W = 3;
    localparam int IDX_W  = 8;
    localparam int SLOT_W = 4;
    localparam int MAG_W  = DATA_W + FOLD_W + 1;
    localparam int DEPTH  = 1 << SLOT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [FOLD_W-1:0] fold_sel = '0;
    logic              in_valid = 1'b0;
    logic              in_last = 1'b0;
    logic [IDX_W-1:0]  in_col = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              done;
    logic [IDX_W-1:0]  win_idx;
    logic [MAG_W-1:0]  win_mag;
    logic [SLOT_W-1:0] slot_count;
    logic [SLOT_W-1:0] rd_slot = '0;
    logic [IDX_W-1:0]  rd_idx;

    int total = 0;
    int bad = 0;
    logic signed [DATA_W-1:0] pv [0:39][0:7];
    int mmem [0:DEPTH-1];
    int mptr = 0;

    always #10 clk = ~clk;

    corr_argmax_sel u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fold_sel(fold_sel),
        .in_valid(in_valid), .in_last(in_last), .in_col(in_col), .in_data(in_data),
        .done(done), .win_idx(win_idx), .win_mag(win_mag),
        .slot_count(slot_count), .rd_slot(rd_slot), .rd_idx(rd_idx)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint absv(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic bubble();
        in_valid = 1'b0;
        in_last  = 1'($urandom);
        in_data  = DATA_W'($urandom);
        in_col   = IDX_W'($urandom);
        @(negedge clk);
    endtask

    // mode 0: random, 1: equal-magnitude pair among small values, 2: most negative input
    task automatic sweep(input int ncols, input int fsel, input int mode);
        int base;
        longint best;
        longint s;
        int bidx;
        base = $urandom_range(255 - ncols, 0);
        fold_sel = FOLD_W'(fsel);
        for (int c = 0; c < ncols; c++) begin
            for (int p = 0; p <= fsel; p++) begin
                if (mode == 0) pv[c][p] = DATA_W'($urandom);
                else if (mode == 1) pv[c][p] = DATA_W'(int'($urandom_range(40, 0)) - 20);
                else pv[c][p] = DATA_W'(int'($urandom_range(60000, 0)) - 30000);
            end
        end
        if (mode == 1) begin
            pv[2][0] = 16'sd300;
            pv[5][0] = -16'sd300;
        end
        if (mode == 2) pv[4][0] = 16'h8000;
        best = -1;
        bidx = 0;
        for (int c = 0; c < ncols; c++) begin
            s = 0;
            for (int p = 0; p <= fsel; p++) s += longint'(pv[c][p]);
            if (absv(s) > best) begin
                best = absv(s);
                bidx = base + c;
            end
        end
        for (int c = 0; c < ncols; c++) begin
            for (int p = 0; p <= fsel; p++) begin
                if ($urandom_range(3, 0) == 0) bubble();
                in_valid = 1'b1;
                in_data  = pv[c][p];
                in_col   = IDX_W'(base + c);
                in_last  = (c == ncols - 1) && (p == fsel);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(done == 1'b0, "R6 early done", longint'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R6 done pulse", longint'(done), 1);
        chk(int'(win_idx) == bidx, "R3 R4 R2 winner index", longint'(win_idx), longint'(bidx));
        chk(longint'(win_mag) == best, "R3 R5 R2 winner magnitude", longint'(win_mag), best);
        mmem[mptr] = bidx;
        mptr = (mptr + 1) % DEPTH;
        @(negedge clk);
        chk(done == 1'b0, "R6 single cycle", longint'(done), 0);
        chk(int'(slot_count) == mptr, "R7 pointer", longint'(slot_count), longint'(mptr));
    endtask

    task automatic read_all();
        for (int s = 0; s < DEPTH; s++) begin
            rd_slot = SLOT_W'(s);
            @(negedge clk);
            chk(int'(rd_idx) == mmem[s], "R9 R7 readback", longint'(rd_idx), longint'(mmem[s]));
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) mmem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done", longint'(done), 0);
        chk(slot_count == '0, "R1 slot_count", longint'(slot_count), 0);
        for (int s = 0; s < 4; s++) begin
            rd_slot = SLOT_W'(s);
            @(negedge clk);
            chk(rd_idx == '0, "R1 read zero", longint'(rd_idx), 0);
        end
        // R2 R3 R10: random sweeps, with and without folding, idle cycles mixed in
        sweep(12, 0, 0);
        for (int k = 0; k < 5; k++) sweep($urandom_range(40, 1), $urandom_range(7, 0), 0);
        sweep(6, 7, 0);
        // R4: equal magnitudes, opposite signs
        sweep(8, 0, 1);
        // R5: most negative input
        sweep(9, 0, 2);
        read_all();
        // R8: start discards a held best
        fold_sel = '0;
        in_valid = 1'b1; in_data = 16'h8000; in_col = 8'd9; in_last = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mptr = 0;
        chk(slot_count == '0, "R8 pointer cleared", longint'(slot_count), 0);
        sweep(8, 0, 1);
        // R8: start discards a partly summed column
        fold_sel = 3'd2;
        in_valid = 1'b1; in_data = 16'sd30000; in_col = 8'd1; in_last = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mptr = 0;
        chk(slot_count == '0, "R8 pointer cleared again", longint'(slot_count), 0);
        sweep(5, 2, 0);
        // R7: more appends than slots, pointer wraps
        for (int k = 0; k < DEPTH + 2; k++) sweep($urandom_range(4, 1), $urandom_range(3, 0), 0);
        chk(int'(slot_count) == mptr, "R7 wrap", longint'(slot_count), longint'(mptr));
        read_all();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule